// File: doc/BRIEF.md
# Outer cache range request splitter

This block accepts one cache maintenance request at a time. The request names an operation (invalidate, clean or flush) over a byte range whose end address is exclusive. The block turns the request into a stream of commands for a downstream range engine. Each command carries an opcode, a line-aligned start address and an inclusive line-aligned end address. The block accepts the next request only after it has finished the current one.

Invalidate requests can cover a line only in part. When the start or the end of such a request falls inside a line, the block first issues a single-line clean-and-invalidate for that line. The full lines in between are then handed out as range commands. Clean and flush requests are widened outward to whole lines instead. Every range command stops at the first of three points: the request end, a size cap, or the next page boundary.

A write-through override drops all clean work. A clean request then produces no commands, and a flush request produces only its invalidate half. A one-cycle `done` pulse marks the end of every request, including a request that produces no commands.

Top module: `range_splitter`

## Requirements
- R1: An invalidate request (`req_op` = 0) whose start is not a multiple of LINE_BYTES first emits a line command (`cmd_op` = 0) whose start and end both equal the start address rounded down to a line. Range work then begins at the next line boundary.
- R2: An invalidate request whose end is not a multiple of LINE_BYTES emits a line command for the line holding the end address. This command follows the R1 command if there is one and comes before any range command. The range end is then rounded down to a line.
- R3: A clean (`req_op` = 1) or flush (`req_op` = 2 or 3) request never emits a line command. Its start is rounded down and its end rounded up to LINE_BYTES before splitting.
- R4: The `cmd_end` of every range command equals its exclusive chunk end minus LINE_BYTES. Both `cmd_start` and `cmd_end` are multiples of LINE_BYTES.
- R5: Each chunk starts where the previous one ended. It ends at the smallest of three addresses: the rounded request end, the chunk start plus MAX_BYTES, and the next multiple of PAGE_BYTES above the chunk start.
- R6: In a flush without override, each chunk emits a range clean (`cmd_op` = 1) and then a range invalidate (`cmd_op` = 2) over the same lines. Both come before the next chunk begins. An invalidate request emits only range invalidates.
- R7: While `wt_override` was high at acceptance, a clean request emits no commands and a flush request emits only its range invalidates.
- R8: `done` is high for exactly one cycle. It follows the cycle in which the last command is accepted, and no command is issued after it.
- R9: A request whose rounded start is not below its rounded end emits no range commands. It produces only the line commands of R1 and R2 and the `done` pulse.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the opcode and both addresses of the command hold their values.
- R11: After reset, `req_ready` is high and `cmd_valid` and `done` are low. `req_ready` stays low from acceptance of a request until its `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 or 3 flush |
| req_start | input | ADDR_W | First byte of the range |
| req_end | input | ADDR_W | Byte after the last byte of the range |
| wt_override | input | 1 | Write-through override, sampled with the request |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 2 | 0 line clean-and-invalidate, 1 range clean, 2 range invalidate |
| cmd_start | output | ADDR_W | First line address |
| cmd_end | output | ADDR_W | Last line address, inclusive |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs a small configuration (32-byte lines, 256-byte pages, 64-byte cap) and sweeps the start and end offsets on strides that are not powers of two. This hits starts and ends both aligned and unaligned, and ranges that sit inside one line, span one page, or cross several pages and caps. Every opcode is run with the override both off and on. The difference between the invalidate edge handling and the outward rounding of clean and flush only shows up when the ends are unaligned. The page limit and the size limit only separate when chunks start at different offsets within a page. The engine's ready is stalled pseudo-randomly, which shows whether commands hold steady and whether the clean and invalidate of a flush chunk stay paired.

// File: rtl/range_splitter.sv
module range_splitter #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_BYTES  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_start,
  input  logic [ADDR_W-1:0] req_end,
  input  logic              wt_override,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_start,
  output logic [ADDR_W-1:0] cmd_end,
  output logic              done
);
  localparam int LB = $clog2(LINE_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam int W  = ADDR_W + 1;
  localparam logic [W-1:0] LMASK = W'(LINE_BYTES - 1);
  localparam logic [W-1:0] PMASK = W'(PAGE_BYTES - 1);
  localparam logic [W-1:0] CAP   = W'(MAX_BYTES);
  localparam logic [W-1:0] LINEW = W'(LINE_BYTES);

  localparam logic [1:0] OP_INV = 2'd0, OP_CLN = 2'd1, OP_FLS = 2'd2;
  localparam logic [1:0] C_LINE = 2'd0, C_CLN = 2'd1, C_INV = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_EDGE_S, S_EDGE_E, S_CLEAN, S_INVAL, S_DONE} st_t;

  st_t                state;
  logic [1:0]         op_q;
  logic               wt_q, e_edge;
  logic [W-1:0]       cur, lim;
  logic [ADDR_W-1:0]  sline, eline;

  wire [W-1:0] s_ext = {1'b0, req_start};
  wire [W-1:0] e_ext = {1'b0, req_end};
  wire [W-1:0] s_dn  = s_ext & ~LMASK;
  wire [W-1:0] s_up  = (s_ext + LMASK) & ~LMASK;
  wire [W-1:0] e_dn  = e_ext & ~LMASK;
  wire [W-1:0] e_up  = (e_ext + LMASK) & ~LMASK;
  wire         s_unal = |req_start[LB-1:0];
  wire         e_unal = |req_end[LB-1:0];
  wire         is_inv = (req_op == OP_INV);
  wire [W-1:0] cur_n  = is_inv ? s_up : s_dn;
  wire [W-1:0] lim_n  = is_inv ? e_dn : e_up;

  wire [W-1:0] cap_end  = cur + CAP;
  wire [W-1:0] page_end = (cur | PMASK) + W'(1);
  wire [W-1:0] min_a    = (cap_end < lim) ? cap_end : lim;
  wire [W-1:0] ce       = (page_end < min_a) ? page_end : min_a;
  wire [W-1:0] ce_last  = ce - LINEW;

  function automatic st_t first_st(input logic [1:0] op, input logic wt);
    if (op == OP_INV || (op != OP_CLN && wt)) return S_INVAL;
    return S_CLEAN;
  endfunction

  function automatic st_t chunk_or_done(input logic [1:0] op, input logic wt,
                                        input logic [W-1:0] c, input logic [W-1:0] l);
    if (c >= l || (op == OP_CLN && wt)) return S_DONE;
    return first_st(op, wt);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_INV;
      wt_q   <= 1'b0;
      e_edge <= 1'b0;
      cur    <= '0;
      lim    <= '0;
      sline  <= '0;
      eline  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          wt_q   <= wt_override;
          e_edge <= is_inv && e_unal;
          cur    <= cur_n;
          lim    <= lim_n;
          sline  <= s_dn[ADDR_W-1:0];
          eline  <= e_dn[ADDR_W-1:0];
          if (is_inv && s_unal)      state <= S_EDGE_S;
          else if (is_inv && e_unal) state <= S_EDGE_E;
          else                       state <= chunk_or_done(req_op, wt_override, cur_n, lim_n);
        end
        S_EDGE_S: if (cmd_ready)
          state <= e_edge ? S_EDGE_E : chunk_or_done(op_q, wt_q, cur, lim);
        S_EDGE_E: if (cmd_ready)
          state <= chunk_or_done(op_q, wt_q, cur, lim);
        S_CLEAN: if (cmd_ready) begin
          if (op_q != OP_CLN) state <= S_INVAL;
          else begin
            cur   <= ce;
            state <= (ce >= lim) ? S_DONE : S_CLEAN;
          end
        end
        S_INVAL: if (cmd_ready) begin
          cur   <= ce;
          state <= (ce >= lim) ? S_DONE : first_st(op_q, wt_q);
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign cmd_valid = (state == S_EDGE_S) || (state == S_EDGE_E) ||
                     (state == S_CLEAN)  || (state == S_INVAL);
  assign cmd_op    = (state == S_CLEAN) ? C_CLN : (state == S_INVAL) ? C_INV : C_LINE;
  assign cmd_start = (state == S_EDGE_S) ? sline :
                     (state == S_EDGE_E) ? eline : cur[ADDR_W-1:0];
  assign cmd_end   = (state == S_EDGE_S) ? sline :
                     (state == S_EDGE_E) ? eline : ce_last[ADDR_W-1:0];

  // R4
  line_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start[LB-1:0] == '0 && cmd_end[LB-1:0] == '0 && cmd_end >= cmd_start));
  // R5
  one_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_start[ADDR_W-1:PB] == cmd_end[ADDR_W-1:PB]));
  // R5
  size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_end - cmd_start) <= ADDR_W'(MAX_BYTES - LINE_BYTES)));
  // R10
  hold_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_start) && $stable(cmd_end)));
  // R7
  no_wt_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == C_CLN) |-> !wt_q);
  // R6
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == C_CLN && op_q != OP_CLN) |=>
      (cmd_valid && cmd_op == C_INV && $stable(cmd_start) && $stable(cmd_end)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready && !cmd_valid));
  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);
endmodule

// File: tb/tb_range_splitter.sv
module tb_range_splitter;
  localparam int L = 32, P = 256, M = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req_valid, req_ready, wt_override, cmd_valid, cmd_ready, done;
  logic [1:0]  req_op, cmd_op;
  logic [31:0] req_start, req_end, cmd_start, cmd_end;

  range_splitter #(.ADDR_W(32), .LINE_BYTES(L), .PAGE_BYTES(P), .MAX_BYTES(M)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_start(req_start), .req_end(req_end), .wt_override(wt_override),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .done(done));

  int n_chk = 0, n_fail = 0;
  int eo[128];
  longint es[128], ee[128];
  int ne;
  logic [7:0] lfsr = 8'h5b;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int o, input longint a, input longint b);
    eo[ne] = o; es[ne] = a; ee[ne] = b; ne++;
  endtask

  task automatic model(input int op, input longint s, input longint e, input bit wt);
    longint c, l, ce, lm;
    ne = 0;
    lm = L - 1;
    if (op == 0) begin
      c = (s + lm) / L * L;
      l = e / L * L;
      if (s % L != 0) push(0, s / L * L, s / L * L);
      if (e % L != 0) push(0, e / L * L, e / L * L);
    end else begin
      c = s / L * L;
      l = (e + lm) / L * L;
    end
    if (op == 1 && wt) return;
    while (c < l) begin
      ce = l;
      if (c + M < ce) ce = c + M;
      if ((c / P + 1) * P < ce) ce = (c / P + 1) * P;
      if (op != 0 && !wt) push(1, c, ce - L);
      if (op != 1) push(2, c, ce - L);
      c = ce;
    end
  endtask

  task automatic run(input int op, input longint s, input longint e, input bit wt);
    int idx, cyc;
    bit got, stalled;
    logic [1:0] po;
    logic [31:0] ps, pe;
    string tag, dtag;
    model(op, s, e, wt);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_start = 32'(s); req_end = 32'(e); wt_override = wt;
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0; got = 0; stalled = 0; cyc = 0;
    po = '0; ps = '0; pe = '0;
    while (!got && cyc < 500) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_ready = lfsr[0] | lfsr[1];
      #1;
      if (stalled)
        check(cmd_valid && cmd_op == po && cmd_start == ps && cmd_end == pe,
              "R10", "held command", longint'(cmd_start), longint'(ps));
      stalled = cmd_valid && !cmd_ready;
      po = cmd_op; ps = cmd_start; pe = cmd_end;
      if (cmd_valid) check(!req_ready, "R11", "ready while busy", 1, 0);
      if (cmd_valid && cmd_ready) begin
        if (idx >= ne) check(0, "R8", "extra command", idx, ne);
        else begin
          if (eo[idx] == 0)      tag = "R1 R2";
          else if (op == 1)      tag = "R3 R5";
          else if (op != 0)      tag = wt ? "R7" : "R6";
          else                   tag = "R4 R5";
          check(cmd_op == 2'(eo[idx]), tag, "opcode", longint'(cmd_op), eo[idx]);
          check(longint'(cmd_start) == es[idx], tag, "start", longint'(cmd_start), es[idx]);
          check(longint'(cmd_end) == ee[idx], tag, "end", longint'(cmd_end), ee[idx]);
        end
        idx++;
      end
      if (done) begin
        dtag = (op == 1 && wt) ? "R7" : (ne == 0 ? "R9" : "R8");
        check(idx == ne, dtag, "commands before done", idx, ne);
        got = 1;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    check(got, "R8", "done seen", 0, 1);
    @(negedge clk);
    check(!done && req_ready, "R8", "single done pulse", longint'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_start = '0; req_end = '0;
    wt_override = 1'b0; cmd_ready = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(req_ready && !cmd_valid && !done, "R11", "reset state",
          longint'({req_ready, cmd_valid, done}), 4);
    rst_n = 1'b1;
    for (int si = 0; si < 26; si++) begin
      for (int ei = 0; ei < 17; ei++) begin
        for (int op = 0; op < 3; op++) begin
          for (int wt = 0; wt < 2; wt++) begin
            longint s, e;
            s = 64'h8000_0040 + si * 23;
            e = s + ei * 21;
            run(op, s, e, wt[0]);
          end
        end
      end
    end
    run(3, 64'h8000_00f0, 64'h8000_0310, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule